// File: doc/BRIEF.md
# Two-Level Local History Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It holds a small direct-mapped table. Each slot remembers the full address of one branch, a 3-bit record of that branch's latest outcomes, and eight 2-bit saturating counters. The record of outcomes picks which of the slot's eight counters gives the prediction. Two branches with the same index therefore keep separate state, and so does one branch whose behaviour follows a repeating pattern.

The fetch stage places the fetch address on the lookup port and reads the hit and predict-taken outputs in the same cycle. Both outputs are combinational reads of the table. When a branch resolves, the execute stage presents the branch address and its outcome on the update port for one cycle. The table changes at that clock edge. A lookup in the same cycle still sees the old contents.

Top module: `lhp_predictor`

## Requirements
- R1: After reset every slot is empty, so every lookup gives hit = 0 and taken = 0.
- R2: The slot is chosen by lookup address bits [IDX_W+1:2]. A hit needs a valid slot whose stored address equals the whole lookup address. Two addresses that share an index but differ elsewhere do not hit on each other's state.
- R3: Counter codes are 00 strong not-taken, 01 weak not-taken, 10 weak taken and 11 strong taken. Taken is 1 only when hit is 1 and the counter chosen by the slot's current history holds 10 or 11.
- R4: An update whose address misses its slot claims that slot. It stores the address, clears the history to 000 and sets all eight counters to 01. It then applies the outcome exactly as a hit would.
- R5: An update that hits moves only the counter chosen by the history as it stood before the update. The counter moves one step toward taken on a taken outcome and one step toward not-taken on a not-taken outcome.
- R6: On every update the slot's history becomes {old[1:0], outcome}, with 1 for taken. The oldest bit is lost.
- R7: Counters saturate. Taken at 11 stays at 11, and not-taken at 00 stays at 00.
- R8: A counter in a strong state needs two opposing outcomes before its prediction flips.
- R9: An update is visible to a lookup from the next cycle on. A lookup in the same cycle as the update sees the state from before it.
- R10: Without an update the table holds its contents, so a steady lookup address gives steady outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| lk_pc | input | PC_W | Fetch address to look up |
| lk_hit | output | 1 | Slot holds this exact address |
| lk_taken | output | 1 | Predict taken |
| up_valid | input | 1 | Resolved branch present this cycle |
| up_pc | input | PC_W | Address of the resolved branch |
| up_taken | input | 1 | Resolved outcome, 1 = taken |

## Verification
The bound checker watches several rules on every clock. A taken prediction never appears without a hit. An address that was just updated hits on the next lookup. When no update occurs, the outputs do not move. Counters never jump more than one step, at most one counter in a slot moves per update, and a slot's history is frozen while no update targets it. Only the bench's scenarios can show the exact counter chosen by history, the saturation and hysteresis sequences, eviction by an aliasing address, and the reset state, because these depend on long histories of outcomes.

// File: rtl/lhp_pkg.sv
package lhp_pkg;

  typedef enum logic [1:0] {
    CTR_SNT = 2'b00,
    CTR_WNT = 2'b01,
    CTR_WT  = 2'b10,
    CTR_ST  = 2'b11
  } ctr_e;

  // one saturating step toward the resolved outcome (R5, R7)
  function automatic ctr_e ctr_step(input ctr_e c, input logic taken);
    ctr_e r;
    r = c;
    if (taken) begin
      if (c != CTR_ST) r = ctr_e'(c + 2'd1);
    end else begin
      if (c != CTR_SNT) r = ctr_e'(c - 2'd1);
    end
    return r;
  endfunction

  function automatic logic ctr_says_taken(input ctr_e c);
    return (c == CTR_WT) || (c == CTR_ST);
  endfunction

endpackage

// File: rtl/lhp_entry.sv
module lhp_entry
  import lhp_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int HIST_W = 3,
  localparam int NCTR  = 1 << HIST_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [PC_W-1:0]      wr_pc,
  input  logic                 wr_taken,
  output logic                 valid_o,
  output logic                 alloc_o,
  output logic [PC_W-1:0]      tag_o,
  output logic [HIST_W-1:0]    hist_o,
  output logic [NCTR*2-1:0]    ctr_o
);

  logic              valid_q, valid_n;
  logic [PC_W-1:0]   tag_q, tag_n;
  logic [HIST_W-1:0] hist_q, hist_n, base_hist;
  ctr_e              ctr_q [NCTR];
  ctr_e              ctr_n [NCTR];
  ctr_e              base_ctr [NCTR];
  logic              same_branch, alloc;

  // next state
  always_comb begin
    same_branch = valid_q && (tag_q == wr_pc);
    alloc       = wr_en && !same_branch;
    base_hist   = alloc ? '0 : hist_q;
    for (int k = 0; k < NCTR; k++) begin
      base_ctr[k] = alloc ? CTR_WNT : ctr_q[k];
    end
    valid_n = valid_q;
    tag_n   = tag_q;
    hist_n  = hist_q;
    for (int k = 0; k < NCTR; k++) begin
      ctr_n[k] = ctr_q[k];
    end
    if (wr_en) begin
      valid_n = 1'b1;
      tag_n   = wr_pc;
      for (int k = 0; k < NCTR; k++) begin
        ctr_n[k] = base_ctr[k];
      end
      // counter picked by pre-shift history, then shift in the outcome
      ctr_n[base_hist] = ctr_step(base_ctr[base_hist], wr_taken);
      hist_n = {base_hist[HIST_W-2:0], wr_taken};
    end
  end

  // registers with explicit clock enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      tag_q   <= '0;
      hist_q  <= '0;
      for (int k = 0; k < NCTR; k++) begin
        ctr_q[k] <= CTR_WNT;
      end
    end else if (wr_en) begin
      valid_q <= valid_n;
      tag_q   <= tag_n;
      hist_q  <= hist_n;
      for (int k = 0; k < NCTR; k++) begin
        ctr_q[k] <= ctr_n[k];
      end
    end
  end

  assign valid_o = valid_q;
  assign alloc_o = alloc;
  assign tag_o   = tag_q;
  assign hist_o  = hist_q;

  for (genvar g = 0; g < NCTR; g++) begin : g_flat
    assign ctr_o[g*2 +: 2] = ctr_q[g];
  end

endmodule

// File: rtl/lhp_select.sv
module lhp_select
  import lhp_pkg::*;
#(
  parameter int N      = 4,
  parameter int PC_W   = 32,
  parameter int HIST_W = 3,
  parameter int ALIGN  = 2,
  localparam int NCTR  = 1 << HIST_W,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]             valid_vec,
  input  logic [N*PC_W-1:0]        tag_flat,
  input  logic [N*HIST_W-1:0]      hist_flat,
  input  logic [N*NCTR*2-1:0]      ctr_flat,
  input  logic [PC_W-1:0]          lk_pc,
  output logic                     hit,
  output logic                     taken
);

  logic [IDX_W-1:0]  idx;
  logic [PC_W-1:0]   tag_sel;
  logic [HIST_W-1:0] hist_sel;
  logic [1:0]        ctr_sel;

  always_comb begin
    idx      = lk_pc[ALIGN+IDX_W-1:ALIGN];
    tag_sel  = tag_flat[int'(idx)*PC_W +: PC_W];
    hist_sel = hist_flat[int'(idx)*HIST_W +: HIST_W];
    ctr_sel  = ctr_flat[(int'(idx)*NCTR + int'(hist_sel))*2 +: 2];
    hit      = valid_vec[idx] && (tag_sel == lk_pc);
    taken    = hit && ctr_says_taken(ctr_e'(ctr_sel));
  end

endmodule

// File: rtl/lhp_predictor.sv
module lhp_predictor #(
  parameter int N      = 4,
  parameter int PC_W   = 32,
  parameter int HIST_W = 3,
  parameter int ALIGN  = 2,
  localparam int NCTR  = 1 << HIST_W,
  localparam int IDX_W = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] lk_pc,
  output logic            lk_hit,
  output logic            lk_taken,
  input  logic            up_valid,
  input  logic [PC_W-1:0] up_pc,
  input  logic            up_taken
);

  logic [N-1:0]          wr_vec;
  logic [N-1:0]          alloc_vec;
  logic [N-1:0]          valid_vec;
  logic [N*PC_W-1:0]     tag_flat;
  logic [N*HIST_W-1:0]   hist_flat;
  logic [N*NCTR*2-1:0]   ctr_flat;
  logic [IDX_W-1:0]      up_idx;

  assign up_idx = up_pc[ALIGN+IDX_W-1:ALIGN];

  for (genvar i = 0; i < N; i++) begin : g_slot
    assign wr_vec[i] = up_valid && (up_idx == IDX_W'(i));

    lhp_entry #(
      .PC_W   (PC_W),
      .HIST_W (HIST_W)
    ) u_entry (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_vec[i]),
      .wr_pc    (up_pc),
      .wr_taken (up_taken),
      .valid_o  (valid_vec[i]),
      .alloc_o  (alloc_vec[i]),
      .tag_o    (tag_flat[i*PC_W +: PC_W]),
      .hist_o   (hist_flat[i*HIST_W +: HIST_W]),
      .ctr_o    (ctr_flat[i*NCTR*2 +: NCTR*2])
    );
  end

  lhp_select #(
    .N      (N),
    .PC_W   (PC_W),
    .HIST_W (HIST_W),
    .ALIGN  (ALIGN)
  ) u_select (
    .valid_vec (valid_vec),
    .tag_flat  (tag_flat),
    .hist_flat (hist_flat),
    .ctr_flat  (ctr_flat),
    .lk_pc     (lk_pc),
    .hit       (lk_hit),
    .taken     (lk_taken)
  );

endmodule

// File: rtl/lhp_checker.sv
module lhp_checker #(
  parameter int N      = 4,
  parameter int PC_W   = 32,
  parameter int HIST_W = 3,
  localparam int NCTR  = 1 << HIST_W
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [PC_W-1:0]        lk_pc,
  input logic                   lk_hit,
  input logic                   lk_taken,
  input logic                   up_valid,
  input logic [PC_W-1:0]        up_pc,
  input logic [N-1:0]           wr_vec,
  input logic [N-1:0]           alloc_vec,
  input logic [N*HIST_W-1:0]    hist_flat,
  input logic [N*NCTR*2-1:0]    ctr_flat
);

  logic                  prev_up_valid;
  logic [PC_W-1:0]       prev_up_pc;
  logic [PC_W-1:0]       prev_lk_pc;
  logic                  prev_hit, prev_taken;
  logic [N-1:0]          prev_wr, prev_alloc;
  logic [N*HIST_W-1:0]   prev_hist;
  logic [N*NCTR*2-1:0]   prev_ctr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_up_valid <= 1'b0;
      prev_up_pc    <= '0;
      prev_lk_pc    <= '0;
      prev_hit      <= 1'b0;
      prev_taken    <= 1'b0;
      prev_wr       <= '0;
      prev_alloc    <= '0;
      prev_hist     <= '0;
      prev_ctr      <= {N*NCTR{2'b01}};
    end else begin
      prev_up_valid <= up_valid;
      prev_up_pc    <= up_pc;
      prev_lk_pc    <= lk_pc;
      prev_hit      <= lk_hit;
      prev_taken    <= lk_taken;
      prev_wr       <= wr_vec;
      prev_alloc    <= alloc_vec;
      prev_hist     <= hist_flat;
      prev_ctr      <= ctr_flat;
    end
  end

  // R3: a taken prediction needs a hit
  p_taken_needs_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lk_taken |-> lk_hit);

  // R9: an address updated last cycle hits now
  p_update_visible_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_up_valid && (lk_pc == prev_up_pc)) |-> lk_hit);

  // R10: no update and steady address keeps outputs steady
  p_idle_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!prev_up_valid && (lk_pc == prev_lk_pc)) |->
      ((lk_hit == prev_hit) && (lk_taken == prev_taken)));

  for (genvar i = 0; i < N; i++) begin : g_chk
    logic [NCTR-1:0] moved;
    for (genvar k = 0; k < NCTR; k++) begin : g_ctr
      logic [1:0] cur, old;
      assign cur      = ctr_flat[(i*NCTR+k)*2 +: 2];
      assign old      = prev_ctr[(i*NCTR+k)*2 +: 2];
      assign moved[k] = (cur != old);

      // R7: a counter never moves more than one step per update
      p_ctr_one_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !prev_alloc[i] |->
          ((cur == old) || (cur == old + 2'd1) || (cur == old - 2'd1)));
    end

    // R5: at most one counter of a slot moves on an update that hits
    p_one_ctr_moves_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !prev_alloc[i] |-> ($countones(moved) <= 1));

    // R6: history is frozen while no update targets the slot
    p_hist_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !prev_wr[i] |->
        (hist_flat[i*HIST_W +: HIST_W] == prev_hist[i*HIST_W +: HIST_W]));
  end

endmodule

bind lhp_predictor lhp_checker #(
  .N      (N),
  .PC_W   (PC_W),
  .HIST_W (HIST_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .lk_pc     (lk_pc),
  .lk_hit    (lk_hit),
  .lk_taken  (lk_taken),
  .up_valid  (up_valid),
  .up_pc     (up_pc),
  .wr_vec    (wr_vec),
  .alloc_vec (alloc_vec),
  .hist_flat (hist_flat),
  .ctr_flat  (ctr_flat)
);

// File: tb/sim_lhp_predictor.sv
`timescale 1ns/1ps
module sim_lhp_predictor;

  localparam int PC_W = 32;
  localparam logic [31:0] PA = 32'h0000_0100; // index 0
  localparam logic [31:0] PB = 32'h0000_0104; // index 1
  localparam logic [31:0] PC = 32'h0000_0110; // index 0, aliases PA
  localparam logic [31:0] PD = 32'h0000_0108; // index 2
  localparam logic [31:0] Z  = 32'h0;
  localparam int NV = 15;

  // {up_valid, up_pc, up_taken, lk_pc, exp_hit, exp_taken}
  localparam logic [67:0] VEC [NV] = '{
    {1'b0, Z,  1'b0, PA, 1'b0, 1'b0}, // 0 R1 empty
    {1'b1, PA, 1'b1, PA, 1'b0, 1'b0}, // 1 R9 same-cycle miss, R4 alloc
    {1'b1, PA, 1'b1, PA, 1'b1, 1'b0}, // 2 h=001 c1=01
    {1'b1, PA, 1'b1, PA, 1'b1, 1'b0}, // 3 h=011 c3=01
    {1'b1, PA, 1'b1, PA, 1'b1, 1'b0}, // 4 h=111 c7=01
    {1'b1, PA, 1'b1, PA, 1'b1, 1'b1}, // 5 c7=10
    {1'b1, PA, 1'b1, PA, 1'b1, 1'b1}, // 6 c7=11
    {1'b1, PA, 1'b0, PA, 1'b1, 1'b1}, // 7 c7 stays 11
    {1'b1, PA, 1'b1, PA, 1'b1, 1'b0}, // 8 h=110 c6=01
    {1'b0, Z,  1'b0, PA, 1'b1, 1'b0}, // 9 h=101 c5=01
    {1'b1, PB, 1'b0, PB, 1'b0, 1'b0}, // 10 PB miss
    {1'b0, Z,  1'b0, PB, 1'b1, 1'b0}, // 11 PB c0=00
    {1'b1, PC, 1'b0, PC, 1'b0, 1'b0}, // 12 alias misses
    {1'b0, Z,  1'b0, PA, 1'b0, 1'b0}, // 13 PA evicted
    {1'b0, Z,  1'b0, PC, 1'b1, 1'b0}  // 14 PC c0=00
  };

  logic            clk, rst_n;
  logic [PC_W-1:0] lk_pc, up_pc;
  logic            lk_hit, lk_taken, up_valid, up_taken;
  int checks, errors;
  bit done;

  lhp_predictor u0 (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_hit(lk_hit),
    .lk_taken(lk_taken), .up_valid(up_valid), .up_pc(up_pc),
    .up_taken(up_taken)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic string req_of(input int i);
    case (i)
      0:       return "R1";
      1:       return "R9/R4";
      2, 3, 4: return "R6/R3";
      5:       return "R5";
      6, 7:    return "R7";
      8, 9:    return "R6/R10";
      10, 11:  return "R4";
      default: return "R2";
    endcase
  endfunction

  task automatic check2(input string req, input logic eh, input logic et);
    checks++;
    if (lk_hit !== eh || lk_taken !== et) begin
      errors++;
      $display("FAIL %s: hit/taken got %b%b expected %b%b", req, lk_hit, lk_taken, eh, et);
    end
  endtask

  // drive after the falling edge, sample before the next rising edge
  task automatic step(input logic uv, input logic [31:0] upc, input logic ut,
                      input logic [31:0] lpc, input logic eh, input logic et,
                      input string req, input bit do_chk);
    @(negedge clk);
    up_valid = uv; up_pc = upc; up_taken = ut; lk_pc = lpc;
    #1;
    if (do_chk) check2(req, eh, et);
  endtask

  task automatic upd(input logic [31:0] pc, input logic t);
    step(1'b1, pc, t, pc, 1'b0, 1'b0, "", 1'b0);
  endtask

  initial begin
    checks = 0; errors = 0; done = 0;
    rst_n = 1'b0; up_valid = 1'b0; up_pc = '0; up_taken = 1'b0; lk_pc = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][67], VEC[i][66:35], VEC[i][34], VEC[i][33:2],
           VEC[i][1], VEC[i][0], req_of(i), 1'b1);
    end

    // R8: strong not-taken needs two taken outcomes to flip
    upd(PD, 1'b0); upd(PD, 1'b0); upd(PD, 1'b1);
    upd(PD, 1'b0); upd(PD, 1'b0); upd(PD, 1'b0);
    step(1'b0, Z, 1'b0, PD, 1'b1, 1'b0, "R8 one flip", 1'b1);
    upd(PD, 1'b1); upd(PD, 1'b0); upd(PD, 1'b0); upd(PD, 1'b0);
    step(1'b0, Z, 1'b0, PD, 1'b1, 1'b1, "R8 two flips", 1'b1);

    // R10: idle cycles keep the prediction
    for (int k = 0; k < 3; k++) step(1'b0, Z, 1'b0, PD, 1'b1, 1'b1, "R10 idle", 1'b1);
    // R2: neighbour slot untouched
    step(1'b0, Z, 1'b0, PB, 1'b1, 1'b0, "R2 other slot", 1'b1);

    // R1: mid-run reset empties the table
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    step(1'b0, Z, 1'b0, PD, 1'b0, 1'b0, "R1 after reset", 1'b1);
    step(1'b0, Z, 1'b0, PB, 1'b0, 1'b0, "R1 after reset", 1'b1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule